// File: doc/BRIEF.md
# Capture/Reload Sixteen-Bit Timer-Counter

A general-purpose timer-counter with a parameterized width (16 bits by default). It is meant to sit next to a small controller core and share that core's machine-cycle tick. The count source is chosen by a select input. One source is the tick itself (timer function). The other is an external count pin, sampled once per tick, where a falling edge is accepted only after a high sample is followed by a low sample (counter function).

In capture mode the counter counts up and wraps through zero. When the edge-enable input is set, a falling edge on an auxiliary pin, also sampled on ticks, latches the current count into the capture/reload register and raises the external flag.

In auto-reload mode a rollover restores the count from that same register. When the down-enable input is set, the auxiliary pin level picks the direction. An underflow then happens when the count reaches the reload value, and it loads the all-ones value. The external flag toggles on each rollover.

Both flags are sticky and change only through the write port. The count and the capture/reload register are readable and writable at any time.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset the count, the capture/reload register and both flags are zero.
- R2: In timer function with run set, the count rises by one on every tick. In capture mode a step from 0xFFFF gives 0x0000 and sets the overflow flag.
- R3: In counter function the count pin is sampled only on ticks. The count steps only on a tick whose sample is low when the previous tick's sample was high; the sampler holds 0 after reset.
- R4: While run is low the count never changes, except by a write to it.
- R5: In capture mode with edge-enable set, an auxiliary-pin falling edge (high sample then low sample, on ticks) copies the count as it stood before that tick into the capture/reload register and sets the external flag. With edge-enable clear, neither changes.
- R6: In auto-reload mode with up counting (down-enable clear, or auxiliary pin high), a step from 0xFFFF loads the capture/reload value and sets the overflow flag.
- R7: In auto-reload mode with down-enable set and the auxiliary pin low, a step decrements the count. A step taken while the count equals the capture/reload value loads 0xFFFF instead and sets the overflow flag.
- R8: In auto-reload mode with down-enable set, the external flag inverts on every rollover in either direction. With down-enable clear, the auxiliary pin level has no effect on direction and the external flag is untouched.
- R9: Flags are sticky. A write with select 2 loads the overflow flag from data bit 0 and the external flag from data bit 1. A flag event in the same cycle takes precedence over the write.
- R10: A write with select 0 loads the count and suppresses counting in that cycle. A write with select 1 loads the capture/reload register, but a capture in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-clock machine-cycle tick |
| run_i | input | 1 | Counting enable |
| mode_i | input | 1 | 0 capture, 1 auto-reload |
| cnt_sel_i | input | 1 | 0 timer (ticks), 1 counter (count pin edges) |
| edge_en_i | input | 1 | Enable capture on auxiliary falling edge |
| down_en_i | input | 1 | Let auxiliary pin choose direction in auto-reload |
| cnt_pin_i | input | 1 | External count pin |
| aux_pin_i | input | 1 | Auxiliary pin: capture trigger or direction |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | 0 count, 1 capture/reload, 2 flags |
| wr_data_i | input | W | Write data |
| count_o | output | W | Current count |
| cap_o | output | W | Capture/reload register |
| ovf_flag_o | output | 1 | Overflow/underflow flag |
| ext_flag_o | output | 1 | External-event flag |

## Verification
The bench uses the default 16-bit width and preloads the count and reload values within a few steps of 0xFFFF and of the reload value. Every rollover in both directions is therefore reached within a few dozen ticks. It sweeps all combinations of mode, source, edge-enable and down-enable, with run held high or driven by a pseudo-random stream, and drives pseudo-random pin levels. An arithmetic model predicts the count, register and flags after every tick. Directed cycles then exercise write/event collisions.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam logic [1:0] WSEL_CNT = 2'd0;
  localparam logic [1:0] WSEL_RLD = 2'd1;
  localparam logic [1:0] WSEL_FLG = 2'd2;
  typedef enum logic {MODE_CAPTURE = 1'b0, MODE_RELOAD = 1'b1} tc_mode_e;
endpackage

// File: rtl/tc_fall_sampler.sv
module tc_fall_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pin_i,
  output logic fall_o
);
  logic samp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     samp_q <= 1'b0;
    else if (tick_i) samp_q <= pin_i;
  end

  // high sample on previous tick, low sample on this one
  assign fall_o = tick_i & samp_q & ~pin_i;

  AST_FALL_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> !fall_o); // R3
endmodule

// File: rtl/tc_counter.sv
module tc_counter import tc_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         run_i,
  input  tc_mode_e     mode_i,
  input  logic         cnt_sel_i,
  input  logic         edge_en_i,
  input  logic         down_en_i,
  input  logic         fall_cnt_i,
  input  logic         fall_aux_i,
  input  logic         aux_lvl_i,
  input  logic         wr_cnt_i,
  input  logic         wr_rld_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cap_o,
  output logic         ovf_evt_o,
  output logic         ext_set_o,
  output logic         ext_tog_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q, cnt_d, cap_q, cap_d;
  logic step, up, roll, cap_evt, reload;

  assign reload  = (mode_i == MODE_RELOAD);
  assign step    = run_i & tick_i & (cnt_sel_i ? fall_cnt_i : 1'b1) & ~wr_cnt_i;
  assign up      = ~reload | ~down_en_i | aux_lvl_i;
  assign cap_evt = ~reload & edge_en_i & fall_aux_i;
  assign roll    = step & (up ? (cnt_q == MAX) : (cnt_q == cap_q));

  always_comb begin
    cnt_d = cnt_q;
    if (wr_cnt_i)  cnt_d = wr_data_i;
    else if (roll) cnt_d = !reload ? '0 : (up ? cap_q : MAX);
    else if (step) cnt_d = up ? cnt_q + 1'b1 : cnt_q - 1'b1;
  end

  always_comb begin
    cap_d = cap_q;
    if (cap_evt)       cap_d = cnt_q;
    else if (wr_rld_i) cap_d = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign cap_o     = cap_q;
  assign ovf_evt_o = roll;
  assign ext_set_o = cap_evt;
  assign ext_tog_o = roll & reload & down_en_i;

  AST_RUN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_cnt_i) |=> $stable(cnt_q)); // R4
  AST_UP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload && up && run_i && tick_i && !wr_cnt_i && !cnt_sel_i && cnt_q == MAX)
      |=> cnt_q == $past(cap_q)); // R6
  AST_DOWN_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload && !up && run_i && tick_i && !wr_cnt_i && !cnt_sel_i && cnt_q == cap_q)
      |=> cnt_q == MAX); // R7
  AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload && edge_en_i && fall_aux_i) |=> cap_q == $past(cnt_q)); // R5
endmodule

// File: rtl/tc_flags.sv
module tc_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ovf_evt_i,
  input  logic       ext_set_i,
  input  logic       ext_tog_i,
  input  logic       wr_flg_i,
  input  logic [1:0] wr_data_i,
  output logic       ovf_o,
  output logic       ext_o
);
  logic ovf_q, ext_q, ovf_d, ext_d;

  // hardware events take precedence over software writes
  always_comb begin
    ovf_d = ovf_q;
    if (ovf_evt_i)     ovf_d = 1'b1;
    else if (wr_flg_i) ovf_d = wr_data_i[0];
    ext_d = ext_q;
    if (ext_set_i)      ext_d = 1'b1;
    else if (ext_tog_i) ext_d = ~ext_q;
    else if (wr_flg_i)  ext_d = wr_data_i[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      ext_q <= ext_d;
    end
  end

  assign ovf_o = ovf_q;
  assign ext_o = ext_q;

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !wr_flg_i) |=> ovf_q); // R9
  AST_EXT_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_tog_i && !ext_set_i) |=> ext_q != $past(ext_q)); // R8
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer import tc_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         mode_i,
  input  logic         cnt_sel_i,
  input  logic         edge_en_i,
  input  logic         down_en_i,
  input  logic         cnt_pin_i,
  input  logic         aux_pin_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] cap_o,
  output logic         ovf_flag_o,
  output logic         ext_flag_o
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pins, falls;
  logic ovf_evt, ext_set, ext_tog;
  tc_mode_e mode;

  assign pins = {aux_pin_i, cnt_pin_i};
  assign mode = tc_mode_e'(mode_i);

  for (genvar g = 0; g < NPIN; g++) begin : g_samp
    tc_fall_sampler u_samp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .pin_i  (pins[g]),
      .fall_o (falls[g])
    );
  end

  tc_counter #(.W(W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .run_i      (run_i),
    .mode_i     (mode),
    .cnt_sel_i  (cnt_sel_i),
    .edge_en_i  (edge_en_i),
    .down_en_i  (down_en_i),
    .fall_cnt_i (falls[0]),
    .fall_aux_i (falls[1]),
    .aux_lvl_i  (aux_pin_i),
    .wr_cnt_i   (wr_en_i && wr_sel_i == WSEL_CNT),
    .wr_rld_i   (wr_en_i && wr_sel_i == WSEL_RLD),
    .wr_data_i  (wr_data_i),
    .cnt_o      (count_o),
    .cap_o      (cap_o),
    .ovf_evt_o  (ovf_evt),
    .ext_set_o  (ext_set),
    .ext_tog_o  (ext_tog)
  );

  tc_flags u_flg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ovf_evt_i (ovf_evt),
    .ext_set_i (ext_set),
    .ext_tog_i (ext_tog),
    .wr_flg_i  (wr_en_i && wr_sel_i == WSEL_FLG),
    .wr_data_i (wr_data_i[1:0]),
    .ovf_o     (ovf_flag_o),
    .ext_o     (ext_flag_o)
  );

  AST_RST_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == WSEL_FLG && wr_data_i[0] && !ovf_flag_o) |=> ovf_flag_o); // R9
endmodule

// File: tb/cap_reload_timer_tb_top.sv
module cap_reload_timer_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 0, run = 0, mode = 0, sel = 0, edg = 0, down = 0;
  logic cpin = 0, apin = 0, we = 0;
  logic [1:0] ws = 0;
  logic [15:0] wd = 0;
  logic [15:0] count, cap;
  logic ovf, ext;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] e_cnt = 0, e_cap = 0;
  logic e_ovf = 0, e_ext = 0, pc = 0, pa = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  cap_reload_timer #(.W(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .run_i(run), .mode_i(mode),
    .cnt_sel_i(sel), .edge_en_i(edg), .down_en_i(down), .cnt_pin_i(cpin),
    .aux_pin_i(apin), .wr_en_i(we), .wr_sel_i(ws), .wr_data_i(wd),
    .count_o(count), .cap_o(cap), .ovf_flag_o(ovf), .ext_flag_o(ext)
  );

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string cnt_tag();
    if (!run) return "R4";
    if (mode && down) return "R7";
    if (mode) return "R6";
    if (sel) return "R3";
    return "R2";
  endfunction

  // one clock with given tick/write; model predicts, outputs compared at next negedge
  task automatic step(input logic tk, input logic w, input logic [1:0] s, input logic [15:0] d, input string tag);
    logic fc, fa, inc, capev, up, ovfev, tog;
    logic [15:0] n_cnt, n_cap;
    string tc, tx;
    tick = tk; we = w; ws = s; wd = d;
    fc = tk && (sel ? (pc && !cpin) : 1'b1);
    fa = tk && pa && !apin;
    if (tk) begin pc = cpin; pa = apin; end
    inc = run && fc && !(w && s == 2'd0);
    capev = !mode && edg && fa;
    n_cnt = e_cnt; n_cap = e_cap; ovfev = 0; tog = 0;
    if (w && s == 2'd0) n_cnt = d;
    if (w && s == 2'd1) n_cap = d;
    if (capev) n_cap = e_cnt;
    if (inc) begin
      up = !mode || !down || apin;
      if (up) begin
        if (e_cnt == 16'hFFFF) begin
          ovfev = 1; tog = mode && down; n_cnt = mode ? e_cap : 16'h0000;
        end else n_cnt = e_cnt + 16'd1;
      end else begin
        if (e_cnt == e_cap) begin ovfev = 1; tog = 1; n_cnt = 16'hFFFF; end
        else n_cnt = e_cnt - 16'd1;
      end
    end
    e_ovf = ovfev ? 1'b1 : ((w && s == 2'd2) ? d[0] : e_ovf);
    e_ext = capev ? 1'b1 : tog ? !e_ext : ((w && s == 2'd2) ? d[1] : e_ext);
    e_cnt = n_cnt; e_cap = n_cap;
    tc = (tag != "") ? tag : (w ? "R10" : cnt_tag());
    tx = (tag != "") ? tag : (w ? "R10" : (mode ? "R8" : "R5"));
    @(negedge clk);
    tick = 0; we = 0;
    check(tc, "count", count, e_cnt);
    check(tx, "cap", cap, e_cap);
    check(tc, "ovf", {15'd0, ovf}, {15'd0, e_ovf});
    check(tx, "ext", {15'd0, ext}, {15'd0, e_ext});
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] v);
    return v[0] ? ((v >> 1) ^ 16'hB400) : (v >> 1);
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    check("R1", "count", count, 16'h0);
    check("R1", "cap", cap, 16'h0);
    check("R1", "flags", {14'd0, ext, ovf}, 16'h0);
    rst_ni = 1;
    @(negedge clk);
    for (int c = 0; c < 32; c++) begin
      mode = c[0]; sel = c[1]; edg = c[2]; down = c[3]; run = 1;
      step(0, 1, 2'd2, 16'h0, "R9");
      step(0, 1, 2'd1, 16'h0100 + 16'(c), "R10");
      step(0, 1, 2'd0, (mode && down) ? 16'h0103 + 16'(c) : 16'hFFFA, "R10");
      for (int t = 0; t < 48; t++) begin
        lfsr = nxt(lfsr);
        cpin = lfsr[0]; apin = lfsr[3];
        if (c[4]) run = lfsr[7];
        step(1, 0, 2'd0, 16'h0, "");
      end
    end
    // flag write both ways
    step(0, 1, 2'd2, 16'h3, "R9");
    step(0, 1, 2'd2, 16'h0, "R9");
    // overflow event beats a clearing flag write in the same cycle
    mode = 1; sel = 0; down = 0; run = 1; edg = 0;
    step(0, 1, 2'd1, 16'h0042, "R10");
    step(0, 1, 2'd0, 16'hFFFF, "R10");
    step(1, 1, 2'd2, 16'h0, "R9");
    // count write suppresses the step
    mode = 0;
    step(1, 1, 2'd0, 16'h1234, "R10");
    // capture beats a reload write
    edg = 1; apin = 1;
    step(1, 0, 2'd0, 16'h0, "R5");
    apin = 0;
    step(1, 1, 2'd1, 16'h5555, "R10");
    // no capture with edge-enable clear
    edg = 0; apin = 1;
    step(1, 0, 2'd0, 16'h0, "R5");
    apin = 0;
    step(1, 0, 2'd0, 16'h0, "R5");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule